// File: doc/BRIEF.md
# Clock lane burst sequencer

This block steps the line state of a serial-link clock lane through one complete high-speed burst. From the low-power stop state (LP-11), a start request sends the lane through a bridge interval (LP-00) and then a zero interval (HS-0). After that the high-speed clock begins toggling. Once the clock has run for a programmed lead-in, the block pulses a ready strobe so the data lanes may begin their own entry into high speed. The clock keeps running until the data lanes report that they are finished. It then runs for a programmed tail, drives HS-0 for the trail interval and returns to LP-11. On that return it raises a one-cycle done flag.

Each interval is a cycle count of the system clock and is supplied on its own input. A count of zero is treated as one cycle. After a burst the lane stays in LP-11 for the programmed low-power hold before another start request is accepted. The lane state leaves the block as a 2-bit code for the analog driver stage.

Top module: `clk_lane_seq`

## Requirements
- R1: After reset the lane code is 00 (LP-11) and the ready and done outputs are low. The code mapping is 00 = LP-11, 01 = LP-00, 10 = HS-0, 11 = HS clock toggling.
- R2: A start request sampled while idle in LP-11 moves the lane code to 01 in the following cycle.
- R3: The lane holds code 01 for exactly the prepare count of cycles.
- R4: After prepare, the lane holds code 10 for exactly the zero count before toggling starts.
- R5: The ready output is high for exactly one cycle: the cycle that follows the first pre-count cycles of code 11.
- R6: Code 11 continues through the cycle in which the data-finished input is sampled high (the earliest such cycle is the ready cycle), and then for exactly the post count more cycles.
- R7: After the clock stops toggling, the lane holds code 10 for exactly the trail count, then returns to code 00.
- R8: The done output is high for exactly one cycle, the first LP-11 cycle after the trail.
- R9: After a burst the lane stays in LP-11 for the low-power hold count, including the done cycle. A start request during that hold is ignored.
- R10: Any interval count of zero behaves as a count of one.
- R11: A start request while a burst is in progress has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a burst |
| dataDone | input | 1 | Data lanes have returned to low power |
| prepCycles | input | CNT_W | LP-00 bridge length |
| zeroCycles | input | CNT_W | HS-0 lead-in length |
| preCycles | input | CNT_W | Clock run before ready |
| postCycles | input | CNT_W | Clock run after data finish |
| trailCycles | input | CNT_W | HS-0 trail length |
| lpxCycles | input | CNT_W | LP-11 hold after a burst |
| laneState | output | 2 | Encoded lane line state |
| clkReady | output | 1 | One-cycle strobe: data lanes may start |
| burstDone | output | 1 | One-cycle strobe: burst complete |

## Verification
The assertions assume two things about the inputs. The interval counts are loaded only when a phase begins, so changing them during a burst changes no interval already under way. The data-finished input is only acted on while the clock is in its open-ended running phase. The stimulus changes the counts only while the lane is idle. It raises data-finished for a single cycle, a chosen number of cycles after ready. It also holds the start request high through the toggling phase and during the post-burst hold, to show that both are ignored.

// File: rtl/clk_lane_seq_pkg.sv
package clk_lane_seq_pkg;

  typedef enum logic [1:0] {
    LANE_LP11  = 2'b00,
    LANE_LP00  = 2'b01,
    LANE_HS0   = 2'b10,
    LANE_HSCLK = 2'b11
  } lane_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PREP,
    PH_ZERO,
    PH_PRE,
    PH_RUN,
    PH_POST,
    PH_TRAIL,
    PH_EXIT
  } phase_e;

  // strobes from control to the interval timer
  typedef struct packed {
    logic   load;
    phase_e sel;
  } tmr_cmd_t;

endpackage

// File: rtl/clk_lane_seq_timer.sv
module clk_lane_seq_timer
  import clk_lane_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_cmd_t         cmd,
  input  logic [CNT_W-1:0] prepCycles,
  input  logic [CNT_W-1:0] zeroCycles,
  input  logic [CNT_W-1:0] preCycles,
  input  logic [CNT_W-1:0] postCycles,
  input  logic [CNT_W-1:0] trailCycles,
  input  logic [CNT_W-1:0] lpxCycles,
  output logic             expired
);

  logic [CNT_W-1:0] pick;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    unique case (cmd.sel)
      PH_PREP:  pick = prepCycles;
      PH_ZERO:  pick = zeroCycles;
      PH_PRE:   pick = preCycles;
      PH_POST:  pick = postCycles;
      PH_TRAIL: pick = trailCycles;
      PH_EXIT:  pick = lpxCycles;
      default:  pick = '0;
    endcase
  end

  // phase of length N: counter starts at N-1, phase ends in the cycle it reads 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (cmd.load) begin
      cnt <= (pick == '0) ? '0 : pick - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign expired = (cnt == '0);

  // R10: without a reload the counter only ever steps down by one
  assert_count_steps_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R10: a zero count reloads as a single-cycle interval
  assert_zero_is_one_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.load && pick == '0) |=> expired);

endmodule

// File: rtl/clk_lane_seq_ctrl.sv
module clk_lane_seq_ctrl
  import clk_lane_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic     dataDone,
  input  logic     expired,
  output tmr_cmd_t cmd,
  output lane_e    laneState,
  output logic     clkReady,
  output logic     burstDone
);

  phase_e phase;
  phase_e nextPhase;

  always_comb begin
    nextPhase = phase;
    unique case (phase)
      PH_IDLE:  if (startReq) nextPhase = PH_PREP;
      PH_PREP:  if (expired)  nextPhase = PH_ZERO;
      PH_ZERO:  if (expired)  nextPhase = PH_PRE;
      PH_PRE:   if (expired)  nextPhase = PH_RUN;
      PH_RUN:   if (dataDone) nextPhase = PH_POST;
      PH_POST:  if (expired)  nextPhase = PH_TRAIL;
      PH_TRAIL: if (expired)  nextPhase = PH_EXIT;
      PH_EXIT:  if (expired)  nextPhase = PH_IDLE;
      default:  nextPhase = PH_IDLE;
    endcase
  end

  assign cmd.load = (nextPhase != phase);
  assign cmd.sel  = nextPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      clkReady  <= 1'b0;
      burstDone <= 1'b0;
    end else begin
      phase     <= nextPhase;
      clkReady  <= (phase == PH_PRE)   && (nextPhase == PH_RUN);
      burstDone <= (phase == PH_TRAIL) && (nextPhase == PH_EXIT);
    end
  end

  always_comb begin
    unique case (phase)
      PH_PREP:                   laneState = LANE_LP00;
      PH_ZERO, PH_TRAIL:         laneState = LANE_HS0;
      PH_PRE, PH_RUN, PH_POST:   laneState = LANE_HSCLK;
      default:                   laneState = LANE_LP11;
    endcase
  end

  assert_start_leaves_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && startReq) |=> (laneState == LANE_LP00));

  assert_prep_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PREP && !expired) |=> (laneState == LANE_LP00));

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    clkReady |=> !clkReady);

  assert_run_waits_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RUN && !dataDone) |=> (phase == PH_RUN));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone);

  assert_done_after_trail_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(burstDone) |-> ($past(laneState) == LANE_HS0 && laneState == LANE_LP11));

  assert_exit_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXIT && !expired) |=> (laneState == LANE_LP11));

  assert_busy_ignores_start_R11: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE && phase != PH_EXIT && $past(phase) == PH_IDLE) |-> (laneState == LANE_LP00));

endmodule

// File: rtl/clk_lane_seq.sv
module clk_lane_seq
  import clk_lane_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             dataDone,
  input  logic [CNT_W-1:0] prepCycles,
  input  logic [CNT_W-1:0] zeroCycles,
  input  logic [CNT_W-1:0] preCycles,
  input  logic [CNT_W-1:0] postCycles,
  input  logic [CNT_W-1:0] trailCycles,
  input  logic [CNT_W-1:0] lpxCycles,
  output logic [1:0]       laneState,
  output logic             clkReady,
  output logic             burstDone
);

  tmr_cmd_t tmrCmd;
  logic     tmrExpired;
  lane_e    laneCode;

  clk_lane_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .dataDone  (dataDone),
    .expired   (tmrExpired),
    .cmd       (tmrCmd),
    .laneState (laneCode),
    .clkReady  (clkReady),
    .burstDone (burstDone)
  );

  clk_lane_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (tmrCmd),
    .prepCycles  (prepCycles),
    .zeroCycles  (zeroCycles),
    .preCycles   (preCycles),
    .postCycles  (postCycles),
    .trailCycles (trailCycles),
    .lpxCycles   (lpxCycles),
    .expired     (tmrExpired)
  );

  assign laneState = laneCode;

endmodule

// File: tb/sim_clk_lane_seq.sv
module sim_clk_lane_seq;

  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic             dataDone = 1'b0;
  logic [CNT_W-1:0] prepCycles = '0;
  logic [CNT_W-1:0] zeroCycles = '0;
  logic [CNT_W-1:0] preCycles = '0;
  logic [CNT_W-1:0] postCycles = '0;
  logic [CNT_W-1:0] trailCycles = '0;
  logic [CNT_W-1:0] lpxCycles = '0;
  logic [1:0]       laneState;
  logic             clkReady;
  logic             burstDone;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  clk_lane_seq #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .dataDone(dataDone),
    .prepCycles(prepCycles), .zeroCycles(zeroCycles), .preCycles(preCycles),
    .postCycles(postCycles), .trailCycles(trailCycles), .lpxCycles(lpxCycles),
    .laneState(laneState), .clkReady(clkReady), .burstDone(burstDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int atLeastOne(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(laneState == 2'b00, "R1 lane after reset", int'(laneState), 0);
    chk(!clkReady && !burstDone, "R1 strobes after reset", int'({clkReady, burstDone}), 0);
  endtask

  // one full burst; w = cycles from ready to the data-finished pulse
  task automatic runBurst(input int p, input int z, input int pr, input int po,
                          input int tr, input int lx, input int w, input string tag);
    int n01 = 0, nZero = 0, n11 = 0, nTrail = 0;
    int readyAt = -1, readyCnt = 0, since = 0, stage = 0, badExit = 0;
    bit seenReady = 1'b0;
    logic [1:0] ls;
    prepCycles = CNT_W'(p); zeroCycles = CNT_W'(z); preCycles = CNT_W'(pr);
    postCycles = CNT_W'(po); trailCycles = CNT_W'(tr); lpxCycles = CNT_W'(lx);
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(laneState == 2'b01, {"R2 start accepted ", tag}, int'(laneState), 1);
    for (int i = 0; i < 4000 && stage < 4; i++) begin
      if (i != 0) @(negedge clk);
      ls = laneState;
      if (stage == 0 && ls == 2'b10) stage = 1;
      if (stage == 1 && ls == 2'b11) stage = 2;
      if (stage == 2 && ls == 2'b10) stage = 3;
      if (stage == 3 && ls == 2'b00) stage = 4;
      if (clkReady) begin
        readyCnt++;
        readyAt = n11;
        seenReady = 1'b1;
      end
      case (stage)
        0: n01++;
        1: nZero++;
        2: n11++;
        3: nTrail++;
        default: ;
      endcase
      if (stage == 2) begin
        startReq = 1'b1;  // R11: start while busy
        dataDone = seenReady && (since == w);
        if (seenReady) since++;
      end else begin
        startReq = 1'b0;
        dataDone = 1'b0;
      end
    end
    chk(stage == 4, {"R7 burst returned to LP-11 ", tag}, stage, 4);
    chk(n01 == atLeastOne(p), {"R3 prepare length ", tag}, n01, atLeastOne(p));
    chk(nZero == atLeastOne(z), {"R4 zero length ", tag}, nZero, atLeastOne(z));
    chk(readyCnt == 1, {"R5 ready pulse count ", tag}, readyCnt, 1);
    chk(readyAt == atLeastOne(pr), {"R5 ready position ", tag}, readyAt, atLeastOne(pr));
    chk(n11 == atLeastOne(pr) + w + 1 + atLeastOne(po), {"R6 R11 toggling length ", tag},
        n11, atLeastOne(pr) + w + 1 + atLeastOne(po));
    chk(nTrail == atLeastOne(tr), {"R7 trail length ", tag}, nTrail, atLeastOne(tr));
    chk(burstDone == 1'b1, {"R8 done on first LP-11 cycle ", tag}, int'(burstDone), 1);
    // R9: start during the post-burst hold must be ignored
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(burstDone == 1'b0, {"R8 done lasts one cycle ", tag}, int'(burstDone), 0);
    for (int k = 0; k < lx + 3; k++) begin
      if (laneState != 2'b00 || burstDone) badExit++;
      @(negedge clk);
    end
    chk(badExit == 0, {"R9 LP-11 hold ignores start ", tag}, badExit, 0);
  endtask

  task automatic testZeroCounts();
    runBurst(0, 0, 0, 0, 0, 0, 0, "all-zero counts R10");
  endtask

  initial begin
    testReset();
    runBurst(3, 4, 8, 2, 5, 4, 3, "nominal");
    testZeroCounts();
    runBurst(6, 1, 2, 7, 3, 1, 10, "long run");
    runBurst(1, 9, 1, 1, 1, 6, 0, "instant data finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule